// File: doc/BRIEF.md
# ISA Extension Register Write Legalizer

This block keeps the register that tells software which instruction-set extensions a hart has turned on. Software may write the register, but the stored value must always be a legal combination. Each write therefore goes through a fixed chain of rules. The chain can drop the whole write, narrow it to what the hart can support, or correct bits that depend on other bits. When the stored value changes, the block raises a flush pulse for one cycle. The rest of the core uses that pulse to discard fetched or translated instructions that were decoded under the old extension set.

The write port has a strobe and a data word. A strap input enables writes for the whole block. A per-hart mask lists the extensions the hart is built with. The address of the next instruction is also an input, because turning off compressed instructions is not safe while that address is only 2-byte aligned. The top two bits hold the native-width code. That field is read-only and is set by the `XLEN` parameter.

Top module: `isa_reg_legalizer`

## Requirements
- R1: While reset is high, and after it is released, `isa_value` equals the native-width code in bits [XLEN-1:XLEN-2]. For XLEN 32, 64 and 128 the code is 1, 2 and 3. Bits [25:0] hold `hart_mask[25:0]` ANDed with the implementable set. All other bits are zero, and `flush_pulse` is 0.
- R2: When `wr_enable` is low, a write with `wr_valid` high changes nothing.
- R3: A write whose data has neither bit 8 (I) nor bit 4 (E) set is discarded completely.
- R4: A write whose data has bit 4 (E) set is discarded completely.
- R5: A write that is accepted stores its data ANDed with `hart_mask`. The result is then ANDed with the implementable set: A bit 0, C bit 2, D bit 3, E bit 4, F bit 5, I bit 8, M bit 12, S bit 18, U bit 20. Bits 29..26 always read as zero.
- R6: After masking, if bit 3 (D) is set and bit 5 (F) is clear, D is cleared before the value is stored.
- R7: A write may try to clear bit 2 (C) while C is currently set. If `next_pc[1:0]` is nonzero at that time, C stays set.
- R8: Bits [XLEN-1:XLEN-2] never change, whatever data is written.
- R9: `flush_pulse` is high for exactly one cycle, in the cycle after the edge where an accepted write changed the stored value. It stays low after writes that leave the value unchanged and after discarded writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | XLEN | Value software writes |
| wr_enable | input | 1 | Strap input; when low, all writes are ignored |
| hart_mask | input | XLEN | Extensions this hart supports |
| next_pc | input | XLEN | Address of the next instruction |
| isa_value | output | XLEN | Stored extension register |
| flush_pulse | output | 1 | One-cycle pulse after the stored value changes |

## Verification
Several properties are checked on every cycle. The width code never moves. No bit outside the implementable set is ever stored, and D is never stored without F. A write without a base bit, a write with E set, or a write made while the strap is low leaves the value unchanged. C cannot drop while the next address is misaligned. The flush output matches exactly the cycles in which the value moved. Only the directed scenarios show the actual stored values. These include masking by the hart's own mask, D being removed when F is missing, C being cleared once the address becomes aligned again, and a rewrite of the same value producing no flush.

// File: rtl/isa_legal_pkg.sv
package isa_legal_pkg;
  localparam int unsigned EXT_W = 26;
  localparam int unsigned BIT_A = 0;
  localparam int unsigned BIT_C = 2;
  localparam int unsigned BIT_D = 3;
  localparam int unsigned BIT_E = 4;
  localparam int unsigned BIT_F = 5;
  localparam int unsigned BIT_I = 8;
  localparam int unsigned BIT_M = 12;
  localparam int unsigned BIT_S = 18;
  localparam int unsigned BIT_U = 20;

  // Extensions this block is able to hold
  function automatic logic [EXT_W-1:0] impl_mask();
    logic [EXT_W-1:0] m;
    m = '0;
    m[BIT_A] = 1'b1;
    m[BIT_C] = 1'b1;
    m[BIT_D] = 1'b1;
    m[BIT_E] = 1'b1;
    m[BIT_F] = 1'b1;
    m[BIT_I] = 1'b1;
    m[BIT_M] = 1'b1;
    m[BIT_S] = 1'b1;
    m[BIT_U] = 1'b1;
    return m;
  endfunction

  function automatic logic [1:0] width_code(int unsigned xlen);
    if (xlen >= 128)     return 2'd3;
    else if (xlen >= 64) return 2'd2;
    else                 return 2'd1;
  endfunction
endpackage

// File: rtl/isa_write_filter.sv
module isa_write_filter
  import isa_legal_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             wr_valid,
  input  logic             wr_enable,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [XLEN-1:0]  hart_mask,
  output logic             accept,
  output logic [EXT_W-1:0] masked_ext
);
  localparam logic [EXT_W-1:0] IMPL = impl_mask();

  logic has_base;
  logic has_e;
  logic unused_hi;

  assign has_e     = wr_data[BIT_E];
  assign has_base  = wr_data[BIT_I] | wr_data[BIT_E];
  // drop rules in order: strap, missing base, embedded base
  assign accept    = wr_valid & wr_enable & has_base & ~has_e;
  assign masked_ext = wr_data[EXT_W-1:0] & hart_mask[EXT_W-1:0] & IMPL;
  assign unused_hi = ^{wr_data[XLEN-1:EXT_W], hart_mask[XLEN-1:EXT_W]};
endmodule

// File: rtl/isa_dep_fixup.sv
module isa_dep_fixup
  import isa_legal_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [EXT_W-1:0] masked_ext,
  input  logic [EXT_W-1:0] cur_ext,
  input  logic [XLEN-1:0]  next_pc,
  output logic [EXT_W-1:0] fixed_ext
);
  logic misaligned;
  logic unused_pc;

  assign misaligned = |next_pc[1:0];
  assign unused_pc  = ^next_pc[XLEN-1:2];

  always_comb begin
    fixed_ext = masked_ext;
    // double precision requires single precision
    if (fixed_ext[BIT_D] && !fixed_ext[BIT_F])
      fixed_ext[BIT_D] = 1'b0;
    // compressed cannot be turned off under a half-word aligned fetch
    if (cur_ext[BIT_C] && !fixed_ext[BIT_C] && misaligned)
      fixed_ext[BIT_C] = 1'b1;
  end
endmodule

// File: rtl/isa_state_reg.sv
module isa_state_reg
  import isa_legal_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EXT_W-1:0] reset_ext,
  input  logic             accept,
  input  logic [EXT_W-1:0] new_ext,
  output logic [EXT_W-1:0] cur_ext,
  output logic [XLEN-1:0]  isa_value,
  output logic             flush_pulse
);
  localparam logic [EXT_W-1:0] IMPL = impl_mask();
  localparam logic [1:0]       WCODE = width_code(XLEN);
  localparam int unsigned      GAP_W = XLEN - EXT_W - 2;

  logic [EXT_W-1:0] ext_q;
  logic             flush_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q   <= reset_ext & IMPL;
      flush_q <= 1'b0;
    end else if (accept) begin
      ext_q   <= new_ext;
      flush_q <= (new_ext != ext_q);
    end else begin
      flush_q <= 1'b0;
    end
  end

  generate
    if (GAP_W > 0) begin : g_gap
      assign isa_value = {WCODE, {GAP_W{1'b0}}, ext_q};
    end else begin : g_nogap
      assign isa_value = {WCODE, ext_q};
    end
  endgenerate

  assign cur_ext     = ext_q;
  assign flush_pulse = flush_q;

  assert_flush_tracks_change_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (flush_pulse == (isa_value != $past(isa_value))));

  assert_width_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(isa_value[XLEN-1:XLEN-2]));
endmodule

// File: rtl/isa_reg_legalizer.sv
module isa_reg_legalizer
  import isa_legal_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_valid,
  input  logic [XLEN-1:0] wr_data,
  input  logic            wr_enable,
  input  logic [XLEN-1:0] hart_mask,
  input  logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] isa_value,
  output logic            flush_pulse
);
  localparam logic [EXT_W-1:0] IMPL = impl_mask();

  logic             accept;
  logic [EXT_W-1:0] masked_ext;
  logic [EXT_W-1:0] fixed_ext;
  logic [EXT_W-1:0] cur_ext;

  isa_write_filter #(.XLEN(XLEN)) u_filter (
    .wr_valid   (wr_valid),
    .wr_enable  (wr_enable),
    .wr_data    (wr_data),
    .hart_mask  (hart_mask),
    .accept     (accept),
    .masked_ext (masked_ext)
  );

  isa_dep_fixup #(.XLEN(XLEN)) u_fixup (
    .masked_ext (masked_ext),
    .cur_ext    (cur_ext),
    .next_pc    (next_pc),
    .fixed_ext  (fixed_ext)
  );

  isa_state_reg #(.XLEN(XLEN)) u_state (
    .clk         (clk),
    .rst         (rst),
    .reset_ext   (hart_mask[EXT_W-1:0]),
    .accept      (accept),
    .new_ext     (fixed_ext),
    .cur_ext     (cur_ext),
    .isa_value   (isa_value),
    .flush_pulse (flush_pulse)
  );

  assert_strap_off_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_enable)) |-> $stable(isa_value));

  assert_no_base_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_data[BIT_I]) && !$past(wr_data[BIT_E])) |-> $stable(isa_value));

  assert_embedded_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_data[BIT_E])) |-> $stable(isa_value));

  assert_only_impl_bits_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> ((isa_value[EXT_W-1:0] & ~IMPL) == '0));

  assert_d_needs_f_R6: assert property (@(posedge clk) disable iff (rst)
    accept |-> !(fixed_ext[BIT_D] && !fixed_ext[BIT_F]));

  assert_c_kept_misaligned_R7: assert property (@(posedge clk) disable iff (rst)
    (isa_value[BIT_C] && (next_pc[1:0] != 2'b00)) |=> isa_value[BIT_C]);
endmodule

// File: tb/isa_reg_legalizer_test.sv
module isa_reg_legalizer_test;
  localparam int XLEN = 32;
  localparam logic [31:0] HMASK = 32'h0014_112F;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_valid = 1'b0;
  logic [XLEN-1:0] wr_data = '0;
  logic            wr_enable = 1'b1;
  logic [XLEN-1:0] hart_mask = HMASK;
  logic [XLEN-1:0] next_pc = 32'h0000_1000;
  logic [XLEN-1:0] isa_value;
  logic            flush_pulse;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  isa_reg_legalizer #(.XLEN(XLEN)) uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_enable(wr_enable), .hart_mask(hart_mask), .next_pc(next_pc),
    .isa_value(isa_value), .flush_pulse(flush_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at falling edge, results visible at the next falling edge
  task automatic do_write(input logic [31:0] d, input logic en, input logic [31:0] pc);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_enable = en; next_pc = pc;
    @(negedge clk);
    wr_valid = 1'b0; wr_data = '0; wr_enable = 1'b1; next_pc = 32'h1000;
  endtask

  task automatic t_reset();
    check("R1 value", isa_value, 32'h4014_112D);
    check("R1 flush", {31'b0, flush_pulse}, 32'h0);
  endtask

  task automatic t_strap_off();
    do_write(32'h0000_0100, 1'b0, 32'h1000);
    check("R2 value", isa_value, 32'h4014_112D);
    check("R2 flush", {31'b0, flush_pulse}, 32'h0);
  endtask

  task automatic t_no_base();
    do_write(32'h0000_1021, 1'b1, 32'h1000);
    check("R3 value", isa_value, 32'h4014_112D);
    check("R3 flush", {31'b0, flush_pulse}, 32'h0);
  endtask

  task automatic t_embedded();
    do_write(32'h0000_0110, 1'b1, 32'h1000);
    check("R4 value", isa_value, 32'h4014_112D);
    check("R4 flush", {31'b0, flush_pulse}, 32'h0);
  endtask

  task automatic t_mask_and_flush();
    do_write(32'h0000_0100, 1'b1, 32'h1000);
    check("R5 narrow", isa_value, 32'h4000_0100);
    check("R9 pulse", {31'b0, flush_pulse}, 32'h1);
    @(negedge clk);
    check("R9 one cycle", {31'b0, flush_pulse}, 32'h0);
    // width code written as 2, gap bits and bit 1 set: all ignored
    do_write(32'hBFFF_FFEF, 1'b1, 32'h1000);
    check("R5/R8 mask", isa_value, 32'h4014_112D);
    check("R9 pulse again", {31'b0, flush_pulse}, 32'h1);
    do_write(32'hBFFF_FFEF, 1'b1, 32'h1000);
    check("R9 same value", {31'b0, flush_pulse}, 32'h0);
  endtask

  task automatic t_d_needs_f();
    do_write(32'h0000_0108, 1'b1, 32'h1000);
    check("R6 D dropped", isa_value, 32'h4000_0100);
    do_write(32'h0000_0128, 1'b1, 32'h1000);
    check("R6 D with F", isa_value, 32'h4000_0128);
  endtask

  task automatic t_c_keep();
    do_write(32'h0000_0104, 1'b1, 32'h1002);
    check("R7 set C", isa_value, 32'h4000_0104);
    do_write(32'h0000_0100, 1'b1, 32'h1002);
    check("R7 kept pc+2", isa_value, 32'h4000_0104);
    check("R7/R9 no flush", {31'b0, flush_pulse}, 32'h0);
    do_write(32'h0000_0100, 1'b1, 32'h1001);
    check("R7 kept pc+1", isa_value, 32'h4000_0104);
    do_write(32'h0000_0100, 1'b1, 32'h1004);
    check("R7 cleared aligned", isa_value, 32'h4000_0100);
    check("R9 flush on clear", {31'b0, flush_pulse}, 32'h1);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_strap_off();
        t_no_base();
        t_embedded();
        t_mask_and_flush();
        t_d_needs_f();
        t_c_keep();
      end
      begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule